// File: doc/BRIEF.md
# Secure Interrupt Group Router

This block takes a set of level-sensitive interrupt lines and routes each one to one of two processor request outputs. The route depends on a security group held for each source. A source in the secure group, or in the secure second group, drives the fast request line. A source in the non-secure second group drives the normal request line. A secure source can never appear on the normal line.

A single configuration port sets the group for each source, along with an enable bit and a priority value. Each access on this port carries a secure flag. Only secure accesses can change the group and group-modifier bitmaps. To a non-secure access, those two bitmaps read as zero. Each output line asserts while at least one enabled, pending source of its class exists. Alongside it, the line presents the number of the winning source on its own identifier bus. The winner is the source with the lowest priority value, and a tie goes to the lower source number.

Top module: `sec_irq_router`

## Requirements
- R1: After reset, every source is disabled and in group 0 with modifier 0 and priority 0, and both request lines and both identifier buses are zero.
- R2: Writes to the group bitmap (offset 1) or the modifier bitmap (offset 2) take effect only when `cfg_secure_i` is 1. Non-secure writes to them leave them unchanged. A non-secure read of either bitmap returns zero, and a secure read returns the stored value.
- R3: The enable bitmap (offset 0, bit i enables source i) and the priority registers (offset NUM_SRC+i, value in the low PRIO_W bits) are writable and readable by any access. Unmapped offsets read as zero.
- R4: Sources are level-sensitive. A source is pending in the cycle after its input is sampled high and stops being pending in the cycle after it is sampled low. Configuration writes take effect on the outputs in the cycle after the write.
- R5: The fast line `fiq_req_o` considers exactly the sources with group bit 0 (secure group 0) or with group bit 1 and modifier bit 1 (secure group 1).
- R6: The normal line `irq_req_o` considers only sources with group bit 1 and modifier bit 0. No secure-class source ever asserts it.
- R7: Among the eligible sources of a line, the identifier is that of the source with the smallest priority value.
- R8: On equal priority values, the lower source number wins.
- R9: A source whose enable bit is 0 never asserts a line, whatever its input.
- R10: While a line is deasserted, its identifier bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt inputs |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_secure_i | input | 1 | 1 marks the current configuration access as secure |
| cfg_addr_i | input | ADDR_W | Configuration register offset |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| cfg_rdata_o | output | DATA_W | Configuration read data for `cfg_addr_i` (combinational) |
| fiq_req_o | output | 1 | Fast request, driven by secure-class sources |
| fiq_id_o | output | ID_W | Number of the winning fast-line source |
| irq_req_o | output | 1 | Normal request, driven by non-secure sources |
| irq_id_o | output | ID_W | Number of the winning normal-line source |

## Verification
A corrupted group or modifier bit sends a source to the wrong line. The fault appears on the very next cycle in which that source is pending and enabled. A secure source that shows up on `irq_req_o` is the most serious form of this fault. A wrong priority value or a wrong tie-break shows as a wrong identifier only when two or more eligible sources are pending together. For that reason the stimulus keeps several sources high at once, with overlapping priority values. A stale pending bit shows one cycle after its input falls, as a request that stays asserted or an identifier that does not change.

// File: rtl/sgr_pkg.sv
// Shared definitions for the secure interrupt group router.
// Assumes a 32-bit configuration data path; bitmap registers use the low
// NUM_SRC bits of that path.
package sgr_pkg;

    // Bitmap register offsets; priority registers start at NUM_SRC.
    localparam int REG_ENABLE   = 0;
    localparam int REG_GROUP    = 1;
    localparam int REG_MODIFIER = 2;

    typedef enum logic [1:0] {
        GRP_SEC0  = 2'd0,
        GRP_SEC1  = 2'd1,
        GRP_NSEC1 = 2'd2
    } sgr_group_e;

    // Map the group bit and modifier bit of one source to its class.
    function automatic sgr_group_e sgr_classify(input logic grp, input logic modif);
        if (!grp)      return GRP_SEC0;
        else if (modif) return GRP_SEC1;
        else            return GRP_NSEC1;
    endfunction

endpackage

// File: rtl/sgr_cfg_regs.sv
// Configuration register file: enable bitmap, group bitmap, modifier bitmap
// and one priority register per source.
// Assumes NUM_SRC is a power of two and not above DATA_W; the top address bit
// selects the priority bank, and the lower bits index the source.
module sgr_cfg_regs
    import sgr_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = $clog2(NUM_SRC) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic                        secure,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output logic [NUM_SRC-1:0]          enable_q,
    output logic [NUM_SRC-1:0]          group_q,
    output logic [NUM_SRC-1:0]          modif_q,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q
);

    localparam int IDX_W = ADDR_W - 1;

    logic prio_sel;
    assign prio_sel = addr[ADDR_W-1];

    // Bitmap registers; group and modifier accept secure writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            group_q  <= '0;
            modif_q  <= '0;
        end else if (we && !prio_sel) begin
            if (addr == ADDR_W'(REG_ENABLE))
                enable_q <= wdata[NUM_SRC-1:0];
            if (addr == ADDR_W'(REG_GROUP) && secure)
                group_q <= wdata[NUM_SRC-1:0];
            if (addr == ADDR_W'(REG_MODIFIER) && secure)
                modif_q <= wdata[NUM_SRC-1:0];
        end
    end

    // Priority bank, one field per source, open to any access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (we && prio_sel) begin
            prio_q[addr[IDX_W-1:0]] <= wdata[PRIO_W-1:0];
        end
    end

    // Read mux; group and modifier read as zero to non-secure accesses.
    always_comb begin
        rdata = '0;
        if (prio_sel) begin
            rdata[PRIO_W-1:0] = prio_q[addr[IDX_W-1:0]];
        end else begin
            case (addr)
                ADDR_W'(REG_ENABLE):   rdata[NUM_SRC-1:0] = enable_q;
                ADDR_W'(REG_GROUP):    if (secure) rdata[NUM_SRC-1:0] = group_q;
                ADDR_W'(REG_MODIFIER): if (secure) rdata[NUM_SRC-1:0] = modif_q;
                default:               rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sgr_prio_arbiter.sv
// Combinational priority picker over NUM_SRC requests.
// The smallest priority value wins, and on equal values the lowest index
// wins. Assumes nothing about the request pattern. When no request is set,
// the identifier is zero.
module sgr_prio_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 4,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic                           valid,
    output logic [ID_W-1:0]                id
);

    logic [PRIO_W:0] best;

    // Linear scan; strict less-than keeps the earlier index on ties.
    always_comb begin
        best  = {1'b1, {PRIO_W{1'b0}}};
        valid = 1'b0;
        id    = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && ({1'b0, prio[i]} < best)) begin
                best  = {1'b0, prio[i]};
                id    = ID_W'(i);
                valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sec_irq_router.sv
// Secure interrupt group router top.
// It samples level-sensitive sources into pending bits, classifies each
// source by its group and modifier bits, and arbitrates the secure classes
// onto the fast line and the non-secure class onto the normal line.
// Assumes synchronous sources; both lines respond one cycle after a change.
module sec_irq_router
    import sgr_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = $clog2(NUM_SRC) + 1,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               cfg_we_i,
    input  logic               cfg_secure_i,
    input  logic [ADDR_W-1:0]  cfg_addr_i,
    input  logic [DATA_W-1:0]  cfg_wdata_i,
    output logic [DATA_W-1:0]  cfg_rdata_o,
    output logic               fiq_req_o,
    output logic [ID_W-1:0]    fiq_id_o,
    output logic               irq_req_o,
    output logic [ID_W-1:0]    irq_id_o
);

    logic [NUM_SRC-1:0]             enable_bits;
    logic [NUM_SRC-1:0]             group_bits;
    logic [NUM_SRC-1:0]             modif_bits;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vals;
    logic [NUM_SRC-1:0]             pend_q;
    logic [NUM_SRC-1:0]             fast_req;
    logic [NUM_SRC-1:0]             norm_req;

    sgr_cfg_regs #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we_i),
        .secure   (cfg_secure_i),
        .addr     (cfg_addr_i),
        .wdata    (cfg_wdata_i),
        .rdata    (cfg_rdata_o),
        .enable_q (enable_bits),
        .group_q  (group_bits),
        .modif_q  (modif_bits),
        .prio_q   (prio_vals)
    );

    // Level-sensitive pending capture, one register per source.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= src_i;
    end

    // Per-source class decode and eligibility for each output line.
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_class
        sgr_group_e cls;
        logic       live;
        assign cls          = sgr_classify(group_bits[gi], modif_bits[gi]);
        assign live         = pend_q[gi] && enable_bits[gi];
        assign fast_req[gi] = live && (cls != GRP_NSEC1);
        assign norm_req[gi] = live && (cls == GRP_NSEC1);
    end

    sgr_prio_arbiter #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_fast_arb (
        .req   (fast_req),
        .prio  (prio_vals),
        .valid (fiq_req_o),
        .id    (fiq_id_o)
    );

    sgr_prio_arbiter #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_norm_arb (
        .req   (norm_req),
        .prio  (prio_vals),
        .valid (irq_req_o),
        .id    (irq_id_o)
    );

endmodule

// File: rtl/sec_irq_router_checker.sv
// Property checker for sec_irq_router, attached by bind below.
// It observes the ports and the register and pending state of the top.
module sec_irq_router_checker #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 6,
    parameter int ID_W    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               cfg_we_i,
    input logic               cfg_secure_i,
    input logic [ADDR_W-1:0]  cfg_addr_i,
    input logic               fiq_req_o,
    input logic [ID_W-1:0]    fiq_id_o,
    input logic               irq_req_o,
    input logic [ID_W-1:0]    irq_id_o,
    input logic [NUM_SRC-1:0] enable_bits,
    input logic [NUM_SRC-1:0] group_bits,
    input logic [NUM_SRC-1:0] modif_bits,
    input logic [NUM_SRC-1:0] pend_q
);

    a_r2_group_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && !cfg_secure_i) |=> ($stable(group_bits) && $stable(modif_bits)));

    a_r4_pend_follows_src: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q == $past(src_i)));

    a_r5_fast_secure_only: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req_o |-> (!group_bits[fiq_id_o] || modif_bits[fiq_id_o]));

    a_r6_normal_nonsecure_only: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (group_bits[irq_id_o] && !modif_bits[irq_id_o]));

    a_r9_fast_enabled_pending: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req_o |-> (enable_bits[fiq_id_o] && pend_q[fiq_id_o]));

    a_r9_normal_enabled_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (enable_bits[irq_id_o] && pend_q[irq_id_o]));

    a_r10_fast_idle_id: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_req_o |-> (fiq_id_o == '0));

    a_r10_normal_idle_id: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> (irq_id_o == '0));

endmodule

bind sec_irq_router sec_irq_router_checker #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_i        (src_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_secure_i (cfg_secure_i),
    .cfg_addr_i   (cfg_addr_i),
    .fiq_req_o    (fiq_req_o),
    .fiq_id_o     (fiq_id_o),
    .irq_req_o    (irq_req_o),
    .irq_id_o     (irq_id_o),
    .enable_bits  (enable_bits),
    .group_bits   (group_bits),
    .modif_bits   (modif_bits),
    .pend_q       (pend_q)
);

// File: tb/sec_irq_router_bench.sv
// Self-checking bench: directed corner cases, then seeded random stimulus,
// compared against a register model kept from the requirements.
module sec_irq_router_bench;

    localparam int N  = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          we = 1'b0;
    logic          sec = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          fiq_req, irq_req;
    logic [4:0]    fiq_id, irq_id;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_en = '0, m_grp = '0, m_mod = '0, m_pend = '0;
    logic [3:0]   m_prio [N];

    always #4 clk = ~clk;

    sec_irq_router u_sec_irq_router (
        .clk(clk), .rst_n(rst_n), .src_i(src), .cfg_we_i(we),
        .cfg_secure_i(sec), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .cfg_rdata_o(rdata), .fiq_req_o(fiq_req), .fiq_id_o(fiq_id),
        .irq_req_o(irq_req), .irq_id_o(irq_id)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Expected winner of one line from the model.
    function automatic void model_line(input bit fast, output bit v, output logic [4:0] id);
        int best = 16;
        v = 1'b0; id = '0;
        for (int i = 0; i < N; i++) begin
            bit ns1 = m_grp[i] && !m_mod[i];
            if (m_pend[i] && m_en[i] && (fast ? !ns1 : ns1) && int'(m_prio[i]) < best) begin
                best = int'(m_prio[i]); v = 1'b1; id = 5'(i);
            end
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [AW-1:0] a, input bit s);
        if (a[AW-1])   return {28'd0, m_prio[a[4:0]]};
        if (a == 6'd0) return m_en;
        if (a == 6'd1) return s ? m_grp : 32'd0;
        if (a == 6'd2) return s ? m_mod : 32'd0;
        return 32'd0;
    endfunction

    task automatic check_lines(input string tag);
        bit v; logic [4:0] id;
        model_line(1'b1, v, id);
        chk(fiq_req == v, {tag, " R5 fast req"}, 32'(fiq_req), 32'(v));
        chk(fiq_id == id, {tag, " R7 fast id"}, 32'(fiq_id), 32'(id));
        model_line(1'b0, v, id);
        chk(irq_req == v, {tag, " R6 normal req"}, 32'(irq_req), 32'(v));
        chk(irq_id == id, {tag, " R7 normal id"}, 32'(irq_id), 32'(id));
    endtask

    // One clock: drive at negedge, update the model at posedge, then check.
    task automatic step(input logic [N-1:0] s, input bit w, input bit sc,
                        input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        src = s; we = w; sec = sc; addr = a; wdata = d;
        @(posedge clk);
        if (w) begin
            if (a[AW-1])          m_prio[a[4:0]] = d[3:0];
            else if (a == 6'd0)   m_en = d;
            else if (a == 6'd1 && sc) m_grp = d;
            else if (a == 6'd2 && sc) m_mod = d;
        end
        m_pend = s;
        #2;
        check_lines(tag);
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input bit sc, input string tag);
        @(negedge clk);
        we = 1'b0; sec = sc; addr = a;
        #2;
        chk(rdata == model_read(a, sc), tag, rdata, model_read(a, sc));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] rs;
        int seed_dummy;
        for (int i = 0; i < N; i++) m_prio[i] = '0;
        seed_dummy = $urandom(32'h5ec1);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!fiq_req && fiq_id == 0, "R1 fast line after reset", {fiq_req, 26'd0, fiq_id}, 0);
        chk(!irq_req && irq_id == 0, "R1 normal line after reset", {irq_req, 26'd0, irq_id}, 0);
        rd_check(6'd0, 1'b1, "R1 enable reset");
        rd_check(6'd1, 1'b1, "R1 group reset");
        rd_check(6'd37, 1'b1, "R1 priority reset");

        // R9: disabled source never asserts
        step(32'h8, 0, 0, 0, 0, "R9 disabled src");
        // R3: non-secure write of enable works
        step(32'h8, 1, 0, 6'd0, 32'h8, "R3 enable write");
        rd_check(6'd0, 1'b0, "R3 enable readback");
        step(32'h0, 0, 0, 0, 0, "R4 source drop");
        step(32'h8, 0, 0, 0, 0, "R4 source rise");

        // R2: non-secure group writes ignored and read zero
        step(32'h8, 1, 0, 6'd1, 32'hFFFF_FFFF, "R2 ns group write");
        rd_check(6'd1, 1'b1, "R2 group unchanged");
        step(32'h8, 1, 1, 6'd1, 32'h8, "R6 secure group write");
        rd_check(6'd1, 1'b0, "R2 ns read zero");
        rd_check(6'd1, 1'b1, "R2 secure read");
        step(32'h8, 1, 0, 6'd2, 32'h8, "R2 ns modifier write");
        rd_check(6'd2, 1'b1, "R2 modifier unchanged");
        step(32'h8, 1, 1, 6'd2, 32'h8, "R5 secure group1");
        step(32'h0, 1, 1, 6'd2, 32'h0, "R10 idle lines");
        rd_check(6'd3, 1'b1, "R3 unmapped read");

        // R8: ties go to the lower number
        step(32'h0, 1, 1, 6'd1, 32'h0, "R8 setup");
        step(32'h0, 1, 0, 6'd0, 32'hFFFF_FFFF, "R8 enable all");
        step(32'h1080, 0, 0, 0, 0, "R8 tie");
        // R7: smaller priority value wins
        step(32'h1080, 1, 0, 6'd39, 32'h5, "R7 prio7");
        step(32'h1080, 1, 0, 6'd44, 32'h2, "R7 prio12");
        rd_check(6'd44, 1'b0, "R3 priority readback");
        step(32'h1080, 1, 0, 6'd0, 32'hFFFF_EFFF, "R9 disable 12");
        // both lines at once
        step(32'h1080, 1, 1, 6'd1, 32'h0000_0F00, "R6 split lines");
        step(32'h1F80, 0, 0, 0, 0, "R5 R6 both lines");

        // Seeded random stimulus
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] ra;
            rs = $urandom;
            ra = 6'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) ra = 6'(32 + $urandom_range(0, 31));
            step(rs & $urandom, $urandom_range(0, 3) == 0, 1'($urandom),
                 ra, $urandom, "random");
        end
        rd_check(6'd1, 1'b1, "R2 final group");
        rd_check(6'd2, 1'b0, "R2 final ns modifier");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule